// File: doc/BRIEF.md
# OR/XOR Multi-Function Register

This block is a parameterised register that can merge an input word into its stored value in one of two ways, selected by two unencoded command pins. One command ORs the input word into the stored value. The other XORs the input word into the stored value. When neither command is raised, the stored value stays as it is. Every bit is an identical cell: a small next-state function of the two commands, the stored bit and the input bit, feeding a flip-flop that has no clock enable.

Raising both commands in the same cycle is illegal. The block does not give that case a function. It holds the stored value, drives a plain error pin high for that cycle, and an assertion reports the event. The stored word and the input word are plain status and data pins, with no handshake. A synchronous reset clears the register to zero.

Top module: `orxor_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, `acc_q` becomes all zeros after that edge.
- R2: With `op_or`=1 and `op_xor`=0 at an edge, `acc_q` becomes the bitwise OR of its old value and `din`.
- R3: With `op_or`=0 and `op_xor`=1 at an edge, `acc_q` becomes the bitwise XOR of its old value and `din`. A bit that is 1 in both words therefore becomes 0.
- R4: With `op_or`=0 and `op_xor`=0 at an edge, `acc_q` keeps its value whatever `din` is.
- R5: With `op_or`=1 and `op_xor`=1 at an edge, `acc_q` keeps its value whatever `din` is.
- R6: `cmd_err` is combinational. It is 1 exactly when `op_or` and `op_xor` are both 1 and `rst` is low. Otherwise it is 0.
- R7: Every bit follows the same rule and uses only its own position of `acc_q` and `din`. The result is therefore correct at the lowest and highest bit positions, and for all-ones and all-zeros words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_or | input | 1 | Command: OR `din` into the register |
| op_xor | input | 1 | Command: XOR `din` into the register |
| din | input | WIDTH | Operand word |
| acc_q | output | WIDTH | Stored register value |
| cmd_err | output | 1 | High while both commands are raised |

## Verification
Two functions can fall in the same cycle: the OR merge and the XOR merge. The bench provokes this by raising both command pins together, with an operand that would visibly change the register under either function. It judges the result by checking three things: `acc_q` is unchanged on the following edge, `cmd_err` is high during the overlap, and `cmd_err` falls again once the commands separate. Reset overlapping a command is also driven, and reset must win.

// File: rtl/orxor_pkg.sv
package orxor_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'b00,
    CMD_XOR  = 2'b01,
    CMD_OR   = 2'b10,
    CMD_BAD  = 2'b11
  } cmd_e;
endpackage

// File: rtl/orxor_cmd_dec.sv
module orxor_cmd_dec
  import orxor_pkg::*;
(
  input  logic op_or,
  input  logic op_xor,
  output cmd_e cmd,
  output logic bad
);
  always_comb begin
    cmd = cmd_e'({op_or, op_xor});
    bad = (cmd == CMD_BAD);
  end
endmodule

// File: rtl/orxor_cell.sv
module orxor_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel_or,
  input  logic sel_xor,
  input  logic b,
  output logic a
);
  logic d;
  // One gate-level function; the both-high case falls back to hold.
  always_comb begin
    d = (sel_or & ~sel_xor & (a | b))
      | (sel_xor & ~sel_or & (a ^ b))
      | (~(sel_or ^ sel_xor) & a);
  end
  always_ff @(posedge clk) begin
    if (rst) a <= 1'b0;
    else     a <= d;
  end
endmodule

// File: rtl/orxor_reg.sv
module orxor_reg
  import orxor_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_or,
  input  logic             op_xor,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] acc_q,
  output logic             cmd_err
);
  cmd_e cmd;
  logic bad;

  orxor_cmd_dec u_dec (.op_or(op_or), .op_xor(op_xor), .cmd(cmd), .bad(bad));

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    orxor_cell u_cell (
      .clk(clk), .rst(rst), .sel_or(op_or), .sel_xor(op_xor),
      .b(din[i]), .a(acc_q[i])
    );
  end

  assign cmd_err = bad & ~rst;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (acc_q == '0)); // R1
  AST_OR_MERGE: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_OR) |=> (acc_q == ($past(acc_q) | $past(din)))); // R2
  AST_XOR_MERGE: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_XOR) |=> (acc_q == ($past(acc_q) ^ $past(din)))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_HOLD) |=> $stable(acc_q)); // R4
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_or && op_xor) |=> $stable(acc_q)); // R5
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cmd_err == (op_or && op_xor))); // R6
endmodule

// File: tb/orxor_reg_test.sv
module orxor_reg_test;
  localparam int W = 8;
  logic clk = 0, rst = 1, op_or = 0, op_xor = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] acc_q;
  logic cmd_err;
  logic [W-1:0] model;
  int checks = 0, errors = 0;
  bit done = 0;

  orxor_reg #(.WIDTH(W)) uut (.clk(clk), .rst(rst), .op_or(op_or), .op_xor(op_xor),
    .din(din), .acc_q(acc_q), .cmd_err(cmd_err));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic o, logic x, logic [W-1:0] d);
    op_or = o; op_xor = x; din = d;
    @(posedge clk); #1;
    if (o && !x) model = model | d;
    else if (x && !o) model = model ^ d;
    op_or = 0; op_xor = 0;
  endtask

  task automatic t_reset();
    rst = 1; op_or = 1; din = '1;
    @(posedge clk); #1;
    chk("R1", acc_q, '0);
    rst = 0; op_or = 0; model = '0;
  endtask

  task automatic t_or();
    step(1, 0, 8'h81); chk("R2", acc_q, model);
    step(1, 0, 8'h3C); chk("R2", acc_q, model);
    step(1, 0, 8'h81); chk("R2", acc_q, 8'hBD);
  endtask

  task automatic t_xor();
    step(0, 1, 8'hFF); chk("R3", acc_q, 8'h42);
    step(0, 1, 8'h42); chk("R3", acc_q, 8'h00);
    step(0, 1, 8'hA5); chk("R3", acc_q, model);
  endtask

  task automatic t_hold();
    step(0, 0, 8'hFF); chk("R4", acc_q, 8'hA5);
    step(0, 0, 8'h5A); chk("R4", acc_q, model);
  endtask

  task automatic t_bad();
    op_or = 1; op_xor = 1; din = 8'h5A;
    #2; checks++;
    if (cmd_err !== 1'b1) begin
      errors++;
      $display("FAIL R6 actual=%b expected=1", cmd_err);
    end
    @(posedge clk); #1;
    chk("R5", acc_q, model);
    op_or = 0; op_xor = 0; #1;
    checks++;
    if (cmd_err !== 1'b0) begin
      errors++;
      $display("FAIL R6 actual=%b expected=0", cmd_err);
    end
  endtask

  task automatic t_edges();
    step(0, 1, model); chk("R7", acc_q, 8'h00);
    step(1, 0, 8'h80); chk("R7", acc_q, 8'h80);
    step(1, 0, 8'h01); chk("R7", acc_q, 8'h81);
    step(1, 0, 8'hFF); chk("R7", acc_q, 8'hFF);
    step(0, 1, 8'h7E); chk("R7", acc_q, 8'h81);
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] r;
      r = W'($urandom);
      step(k[0], ~k[0], r);
      chk(k[0] ? "R2" : "R3", acc_q, model);
    end
  endtask

  initial begin
    model = '0;
    @(posedge clk); #1;
    t_reset();
    t_or();
    t_xor();
    t_hold();
    t_bad();
    t_edges();
    t_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule